// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one counting channel of a timer: an 8-bit up-counter advanced by a one-clock count tick, a compare register, and a shadow buffer that sits in front of the compare register. When the counter reaches the compare value, the channel emits a registered one-clock match pulse. The same channel runs as an interval timer, as a pulse-width modulator whose period is a power of two (2^n ticks, with n of 6, 7 or 8), or as a programmable pulse generator with a 256-tick cycle. In both waveform modes it drives a level output.

Software programs the channel through a write-only port. Address 0 is shared by the compare register and its shadow. Bit 0 of address 1 turns buffering on or off. With buffering off, a write takes effect at once. With buffering on, a write is held in the shadow and moves into the compare register only at a waveform cycle boundary. A duty-cycle change therefore never lands in the middle of a period.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: With mode code 00 (and the unused code 11, which behaves the same), the counter advances by one on each tick. A tick that finds the counter equal to a non-zero compare value C produces a match and returns the counter to 0, so matches repeat every C+1 ticks. wave_out stays 0 in this mode.
- R2: A compare value of 00h never matches a count of zero. The match comes instead on the overflow tick: at count 255 in timer mode and PPG mode, and at count 2^n−1 in PWM mode. In PWM mode a compare value of 00h keeps wave_out at 0.
- R3: match is high for exactly one clock. It is high in the cycle that follows the clock edge at which the tick that found the match was sampled.
- R4: With tick low the counter holds its value and match stays 0.
- R5: Mode code 01 is PWM. The pwm_len codes 00, 01 and 1x give n = 6, 7 and 8. The counter wraps from 2^n−1 to 0. wave_out goes to 1 on the wrap tick and returns to 0 on the match tick.
- R6: Mode code 10 is PPG. The counter wraps from 255 to 0, and that wrap tick starts a new cycle. wave_out goes to 1 on the wrap tick and returns to 0 on the match tick.
- R7: After reset, the counter, the compare register and the shadow are 0, match and wave_out are 0, and buffering is off.
- R8: With buffering off (address 1 bit 0 = 0), a write to address 0 sets both the compare register and the shadow. The new value is used from the next tick onward.
- R9: With buffering on (address 1 bit 0 = 1), a write to address 0 sets only the shadow. The shadow is copied into the compare register on the wrap tick in PWM mode or PPG mode.
- R10: In timer mode no shadow-to-compare copy ever happens. With buffering on, writes to address 0 do not change the match timing.
- R11: When a write to address 0 and a copy occur in the same clock, the copy uses the shadow value from before the write. The newly written value waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address: 0 compare/shadow, 1 control |
| wr_data | input | 8 | Write data; control uses bit 0 as buffer enable |
| tick | input | 1 | Count enable, one clock per count |
| mode | input | 2 | 00 timer, 01 PWM, 10 PPG, 11 as timer |
| pwm_len | input | 2 | PWM length: 00 n=6, 01 n=7, 1x n=8 |
| match | output | 1 | Registered one-clock match pulse |
| wave_out | output | 1 | Waveform level in PWM and PPG modes |

## Verification
Each mode is driven with an unbroken tick stream and a chosen compare value: a small value, a value of 1, a value near the top of the range, and 00h. The positions and number of match pulses show whether the counter clears on a match, wraps at 2^n−1, or wraps at 255. The high-time count of wave_out separates the set-on-wrap and clear-on-match behaviour from a shifted or inverted waveform. The buffered sequences place the shadow write before a boundary, on the boundary clock itself, and in timer mode. A match position that moves, or fails to move, then shows whether the copy happened, when it happened, and which shadow value it used. Gapped ticks and a write in the middle of a period separate a held counter from one that runs freely, and an immediate compare update from a deferred one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DEF_CNT_W  = 8;
  localparam int DEF_ADDR_W = 1;

  // register map
  localparam int CMP_ADDR = 0;
  localparam int CTL_ADDR = 1;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_PWM   = 2'b01,
    MODE_PPG   = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cyc_bnd,
  output logic              buf_en,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [CNT_W-1:0]  shadow_val
);

  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(CMP_ADDR);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);

  logic             buf_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] shd_q;

  logic             wr_cmp;
  logic             wr_ctl;
  logic             ld_shd;
  logic             ld_cmp;
  logic             ld_buf;
  logic [CNT_W-1:0] cmp_d;

  // next-state
  always_comb begin
    wr_cmp = wr_en && (wr_addr == A_CMP);
    wr_ctl = wr_en && (wr_addr == A_CTL);
    ld_shd = wr_cmp;
    ld_buf = wr_ctl;
    ld_cmp = 1'b0;
    cmp_d  = cmp_q;
    if (cyc_bnd && buf_q) begin
      // boundary copy takes the shadow as it stood before this clock
      ld_cmp = 1'b1;
      cmp_d  = shd_q;
    end else if (wr_cmp && !buf_q) begin
      ld_cmp = 1'b1;
      cmp_d  = wr_data;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      buf_q <= 1'b0;
      cmp_q <= '0;
      shd_q <= '0;
    end else begin
      if (ld_buf) begin
        buf_q <= wr_data[0];
      end
      if (ld_cmp) begin
        cmp_q <= cmp_d;
      end
      if (ld_shd) begin
        shd_q <= wr_data;
      end
    end
  end

  assign buf_en     = buf_q;
  assign cmp_val    = cmp_q;
  assign shadow_val = shd_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       pwm_len,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cyc_bnd,
  output logic             match,
  output logic             wave_out
);

  localparam int LEN_CODES = 4;

  logic [CNT_W-1:0] top_tbl [LEN_CODES];

  // PWM wrap points 2^n-1, n = CNT_W-2, CNT_W-1, CNT_W, CNT_W
  for (genvar i = 0; i < LEN_CODES; i++) begin : g_top
    localparam int NBITS = (i == 0) ? CNT_W - 2 : (i == 1) ? CNT_W - 1 : CNT_W;
    assign top_tbl[i] = CNT_W'((64'd1 << NBITS) - 64'd1);
  end

  mode_e            md;
  logic             is_pwm;
  logic             is_ppg;
  logic             is_tmr;
  logic [CNT_W-1:0] top_sel;
  logic             at_top;
  logic             hit;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             match_q;
  logic             match_d;
  logic             wave_q;
  logic             wave_d;
  logic             ld_wave;

  // next-state
  always_comb begin
    md      = mode_e'(mode);
    is_pwm  = (md == MODE_PWM);
    is_ppg  = (md == MODE_PPG);
    is_tmr  = !is_pwm && !is_ppg;
    top_sel = top_tbl[pwm_len];
    at_top  = is_pwm ? (cnt_q == top_sel) : (cnt_q == {CNT_W{1'b1}});
    hit     = (cmp_val == '0) ? at_top : (cnt_q == cmp_val);

    cnt_d = cnt_q + CNT_W'(1);
    if (is_tmr && hit) begin
      cnt_d = '0;
    end else if (is_pwm && at_top) begin
      cnt_d = '0;
    end

    match_d = tick && hit;
    cyc_bnd = tick && at_top && !is_tmr;

    ld_wave = 1'b0;
    wave_d  = wave_q;
    if (is_tmr) begin
      ld_wave = 1'b1;
      wave_d  = 1'b0;
    end else if (tick && hit) begin
      ld_wave = 1'b1;
      wave_d  = 1'b0;
    end else if (tick && at_top) begin
      ld_wave = 1'b1;
      wave_d  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q <= cnt_d;
      end
      match_q <= match_d;
      if (ld_wave) begin
        wave_q <= wave_d;
      end
    end
  end

  assign cnt_val  = cnt_q;
  assign match    = match_q;
  assign wave_out = wave_q;

endmodule

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [1:0]        pwm_len,
  output logic              match,
  output logic              wave_out
);

  logic             rst_ns;
  logic             buf_en;
  logic             cyc_bnd;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] shadow_val;
  logic [CNT_W-1:0] cnt_val;

  tmr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  tmr_cmp_regs #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cyc_bnd    (cyc_bnd),
    .buf_en     (buf_en),
    .cmp_val    (cmp_val),
    .shadow_val (shadow_val)
  );

  tmr_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .tick     (tick),
    .mode     (mode),
    .pwm_len  (pwm_len),
    .cmp_val  (cmp_val),
    .cnt_val  (cnt_val),
    .cyc_bnd  (cyc_bnd),
    .match    (match),
    .wave_out (wave_out)
  );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              tick,
  input logic [1:0]        mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              match,
  input logic              wave_out,
  input logic              buf_en,
  input logic              cyc_bnd,
  input logic [CNT_W-1:0]  cmp_val,
  input logic [CNT_W-1:0]  shadow_val,
  input logic [CNT_W-1:0]  cnt_val
);

  logic wr_cmp;
  logic tmr_mode;

  assign wr_cmp   = wr_en && (wr_addr == ADDR_W'(CMP_ADDR));
  assign tmr_mode = (mode != MODE_PWM) && (mode != MODE_PPG);

  assert_wave_timer_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    tmr_mode |=> !wave_out);

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    match |=> !match);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    !tick |=> (cnt_val == $past(cnt_val)) && !match);

  assert_direct_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_cmp && !buf_en) |=> (cmp_val == $past(wr_data)) && (shadow_val == $past(wr_data)));

  assert_shadow_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_cmp && buf_en && !cyc_bnd) |=> (cmp_val == $past(cmp_val)) && (shadow_val == $past(wr_data)));

  assert_timer_hold_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (tmr_mode && !(wr_cmp && !buf_en)) |=> (cmp_val == $past(cmp_val)));

  assert_reload_old_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (cyc_bnd && buf_en) |=> (cmp_val == $past(shadow_val)));

endmodule

bind dbuf_cmp_timer tmr_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .tick       (tick),
  .mode       (mode),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .match      (match),
  .wave_out   (wave_out),
  .buf_en     (buf_en),
  .cyc_bnd    (cyc_bnd),
  .cmp_val    (cmp_val),
  .shadow_val (shadow_val),
  .cnt_val    (cnt_val)
);

// File: tb/dbuf_cmp_timer_bench.sv
module dbuf_cmp_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [0:0] wr_addr;
  logic [7:0] wr_data;
  logic       tick;
  logic [1:0] mode;
  logic [1:0] pwm_len;
  logic       match;
  logic       wave_out;

  dbuf_cmp_timer u_dbuf_cmp_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tick     (tick),
    .mode     (mode),
    .pwm_len  (pwm_len),
    .match    (match),
    .wave_out (wave_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;
  int hit_at [8];
  int n_hits;
  int wave_hi;

  typedef struct packed {
    logic [1:0] md;
    logic [1:0] ln;
    logic [7:0] cv;
    logic [9:0] nt;
    logic [3:0] ecnt;
    logic [9:0] efirst;
    logic [7:0] ewave;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 2'b00, 8'd5,   10'd20,  4'd3, 10'd5,   8'd0},
    '{2'b00, 2'b00, 8'd0,   10'd300, 4'd1, 10'd255, 8'd0},
    '{2'b01, 2'b00, 8'd10,  10'd150, 4'd3, 10'd10,  8'd22},
    '{2'b01, 2'b01, 8'd10,  10'd150, 4'd2, 10'd10,  8'd11},
    '{2'b01, 2'b10, 8'd200, 10'd300, 4'd1, 10'd200, 8'd45},
    '{2'b01, 2'b00, 8'd0,   10'd150, 4'd2, 10'd63,  8'd0},
    '{2'b10, 2'b00, 8'd3,   10'd300, 4'd2, 10'd3,   8'd4},
    '{2'b00, 2'b00, 8'd1,   10'd10,  4'd5, 10'd1,   8'd0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic clr_stats();
    n_hits  = 0;
    wave_hi = 0;
    for (int i = 0; i < 8; i++) hit_at[i] = -1;
  endtask

  task automatic run_ticks(int n, int wr_k, logic [7:0] wr_v);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      if (k == wr_k) begin
        wr_en   = 1'b1;
        wr_addr = 1'b0;
        wr_data = wr_v;
      end
      @(posedge clk);
      #1;
      tick  = 1'b0;
      wr_en = 1'b0;
      if (match) begin
        if (n_hits < 8) hit_at[n_hits] = k;
        n_hits++;
      end
      if (wave_out) wave_hi++;
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 1'b0;
    wr_data = 8'd0;
    tick    = 1'b0;
    mode    = 2'b00;
    pwm_len = 2'b00;

    // reset state, R7
    do_reset();
    chk("R7 match after reset", int'(match), 0);
    chk("R7 wave after reset", int'(wave_out), 0);

    // vector table: R1 R2 R5 R6, first-match position also covers R3
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      do_reset();
      mode    = VEC[v].md;
      pwm_len = VEC[v].ln;
      wr_reg(1'b0, VEC[v].cv);
      clr_stats();
      run_ticks(int'(VEC[v].nt), -1, 8'd0);
      if (VEC[v].cv == 8'd0) tag = "R2";
      else if (VEC[v].md == 2'b01) tag = "R5";
      else if (VEC[v].md == 2'b10) tag = "R6";
      else tag = "R1";
      chk($sformatf("%s vec%0d match count", tag, v), n_hits, int'(VEC[v].ecnt));
      chk($sformatf("%s vec%0d first match tick (R3)", tag, v), hit_at[0], int'(VEC[v].efirst));
      chk($sformatf("%s vec%0d wave high samples", tag, v), wave_hi, int'(VEC[v].ewave));
    end

    // R7: reset turns buffering off again
    do_reset();
    wr_reg(1'b1, 8'd1);
    do_reset();
    mode = 2'b00;
    wr_reg(1'b0, 8'd5);
    clr_stats();
    run_ticks(20, -1, 8'd0);
    chk("R7 buffer off after reset count", n_hits, 3);
    chk("R7 buffer off after reset first", hit_at[0], 5);

    // R9: PWM buffered, copy at wrap
    do_reset();
    mode = 2'b01; pwm_len = 2'b00;
    wr_reg(1'b0, 8'd10);
    wr_reg(1'b1, 8'd1);
    wr_reg(1'b0, 8'd20);
    clr_stats();
    run_ticks(150, -1, 8'd0);
    chk("R9 pwm buffered count", n_hits, 3);
    chk("R9 pwm buffered first", hit_at[0], 10);
    chk("R9 pwm buffered second", hit_at[1], 84);
    chk("R9 pwm buffered third", hit_at[2], 148);

    // R11: write on the boundary clock
    do_reset();
    mode = 2'b01; pwm_len = 2'b00;
    wr_reg(1'b0, 8'd10);
    wr_reg(1'b1, 8'd1);
    wr_reg(1'b0, 8'd20);
    clr_stats();
    run_ticks(170, 63, 8'd30);
    chk("R11 same-clock second", hit_at[1], 84);
    chk("R11 same-clock third", hit_at[2], 158);

    // R9: PPG buffered, copy at cycle start
    do_reset();
    mode = 2'b10;
    wr_reg(1'b0, 8'd3);
    wr_reg(1'b1, 8'd1);
    wr_reg(1'b0, 8'd50);
    clr_stats();
    run_ticks(320, -1, 8'd0);
    chk("R9 ppg buffered count", n_hits, 2);
    chk("R9 ppg buffered second", hit_at[1], 306);

    // R10: timer mode never copies
    do_reset();
    mode = 2'b00;
    wr_reg(1'b0, 8'd5);
    wr_reg(1'b1, 8'd1);
    wr_reg(1'b0, 8'd9);
    clr_stats();
    run_ticks(300, -1, 8'd0);
    chk("R10 timer buffered count", n_hits, 50);
    chk("R10 timer buffered second", hit_at[1], 11);

    // R8: direct write mid-period
    do_reset();
    mode = 2'b00;
    wr_reg(1'b0, 8'd5);
    clr_stats();
    run_ticks(3, -1, 8'd0);
    wr_reg(1'b0, 8'd8);
    clr_stats();
    run_ticks(10, -1, 8'd0);
    chk("R8 direct write first", hit_at[0], 5);

    // R4 gating, R3 pulse width
    do_reset();
    mode = 2'b00;
    wr_reg(1'b0, 8'd2);
    clr_stats();
    run_ticks(2, -1, 8'd0);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(posedge clk);
        #1;
        if (match) seen++;
      end
      chk("R4 no match while idle", seen + n_hits, 0);
    end
    clr_stats();
    run_ticks(1, -1, 8'd0);
    chk("R4 count held across idle", n_hits, 1);
    @(posedge clk);
    #1;
    chk("R3 match one clock wide", int'(match), 0);

    // R1: spare mode code acts as timer
    do_reset();
    mode = 2'b11;
    wr_reg(1'b0, 8'd4);
    clr_stats();
    run_ticks(12, -1, 8'd0);
    chk("R1 spare mode count", n_hits, 2);
    chk("R1 spare mode second", hit_at[1], 9);
    chk("R1 spare mode wave", wave_hi, 0);

    finish_run();
  end

endmodule